// File: doc/BRIEF.md
# Prefix-Aware Instruction Decoder

This block turns a 16-bit instruction word for a small load/store processor with eight registers, one of which is the program counter, into control fields. It produces the ALU operation, the register indices, the effective immediate, the memory access size, strobes for load, store, branch and link, the base-register update mode for push and pop, controls for reading and writing the flags, a return-from-interrupt marker and an illegal-instruction flag. Its outputs are combinational from the current word and the decoder's state, and they are qualified by `valid_i`.

The decoder keeps two pieces of state between instructions. The first is a pending constant from immediate-prefix words. The second is a pending 2-bit extension code from the alternate-set word. The next ordinary instruction uses both, and then both are cleared. The pending constant is shifted left by the width of that instruction's own constant field and merged with it. The extension code changes the meaning of the instruction: it turns multiply into signed multiply, divide or signed divide, and it turns a word access into a half-word or byte access. Execution, the register file and memory are handled outside this block.

Top module: `insn_prefix_decoder`

## Requirements
- R1: Reset clears the pending constant and the pending extension code. While `valid_i` is low, every strobe, `illegal_o`, `prefix_o`, `use_imm_o`, `usr_src_o` and `addr_mode_o` is 0, `alu_op_o` is 0 (no-op), and the pending state is held.
- R2: Bits 15:12 equal to 0..6 select register-plus-constant ALU ops with `alu_op_o` codes 1..7 (add, adc, rsb, rsbc, and, or, xor). The fields are rd = bits 2:0, rs1 = bits 5:3 and the 6-bit constant = bits 11:6. `use_imm_o` is 1.
- R3: Group 12 is the three-register form. Its op is in bits 11:9, where 0..6 give codes 1..7 and 7 is the multiply class. rs2 = bits 8:6, rs1 = bits 5:3, rd = bits 2:0, and `use_imm_o` is 0.
- R4: Group 7, and group 12 with op 7, decode by the pending extension code: 0, 1, 2 and 3 give codes 8, 9, 10 and 11 (unsigned multiply, signed multiply, unsigned divide, signed divide).
- R5: Group 8 loads into rd = bits 2:0, and group 9 stores the data in rs2 = bits 2:0. Both use base rs1 = bits 5:3 with the 6-bit offset in bits 11:6. `mem_size_o` equals the extension code (0 word, 1 half, 2 byte). Code 3 raises `illegal_o` with no memory strobe.
- R6: Group 10 is branch and group 11 is branch-and-link (`branch_o` and `link_o` both high). The condition `cond_o` is bits 2:0, the base is rs1 = bits 5:3 and the offset is bits 11:6.
- R7: Group 13 loads a 9-bit constant from bits 11:3 into rd = bits 2:0 with `alu_op_o` = 12 (move) and `use_imm_o` = 1.
- R8: Group 14 is a prefix. It raises `prefix_o` and no other strobe. It appends bits 11:0 to the pending constant (pending = pending<<12 | bits). The next constant is pending<<w | k, where w is that instruction's own constant width.
- R9: Word 0xF760 | e is the alternate-set word. It raises `prefix_o` and sets the pending code to e (bits 1:0). Prefix and alternate words leave each other's state alone. Any other valid word, illegal ones included, clears both.
- R10: Bits 15:6 = 1111011000 are push: a word store of data rs2 = bits 2:0 through base rs1 = bits 5:3, with `addr_mode_o` = 1 (post-decrement). Bits 1111011001 are pop: a word load into rd = bits 2:0 with `addr_mode_o` = 2 (pre-increment).
- R11: Bits 15:6 = 1111011101 select flag access by bits 5:3. The value 0 reads the flags into rd = bits 2:0. The value 1 writes them from rs1 = bits 2:0. The values 2 and 3 clear or set the flag at `flag_idx_o` = bits 2:0.
- R12: Bits 15:8 = 0xF4 are a move (code 12) from rs1 = bits 5:3 to rd = bits 2:0. Bit 7 raises `rti_o` (return from interrupt) and bit 6 raises `usr_src_o`.
- R13: Rotates and shifts use codes 13..19: ror, rol, lsl, lsr, ror16, rol16, sign-extend.
  - 0xF0..0xF3 shift rd = rs1 = bits 2:0 by the 5-bit constant in bits 7:3, with the op in bits 9:8.
  - 0xF5 takes the op from bits 7:6 and the amount from rs2 = bits 5:3.
  - Bits 15:6 = 1111011010 or 1111011011 give a register rotate16.
  - 1111011100 gives sign-extend from rs1 = bits 5:3.
  - 0xF8 gives a rotate16 by the 4-bit constant in bits 6:3, with bit 7 selecting rol16.
- R14: The following spare words raise `illegal_o` with `alu_op_o` = 0 and every other strobe low:
  - bits 15:8 = 0xF9..0xFF;
  - bits 15:6 = 1111011110 or 1111011111;
  - flag sub-codes 5..7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Instruction word present this cycle |
| instr_i | input | 16 | Instruction word |
| alu_op_o | output | 5 | ALU operation code |
| rd_o | output | 3 | Destination register |
| rs1_o | output | 3 | First source / base register |
| rs2_o | output | 3 | Second source / store data register |
| imm_o | output | IMM_W | Effective immediate |
| use_imm_o | output | 1 | Second operand is the immediate |
| mem_size_o | output | 2 | Access size: 0 word, 1 half, 2 byte |
| load_o | output | 1 | Load strobe |
| store_o | output | 1 | Store strobe |
| branch_o | output | 1 | Branch strobe |
| link_o | output | 1 | Branch saves return address |
| cond_o | output | 3 | Branch condition |
| addr_mode_o | output | 2 | 0 offset, 1 post-decrement, 2 pre-increment |
| flag_rd_o | output | 1 | Copy flags to rd |
| flag_wr_o | output | 1 | Load flags from rs1 |
| flag_clr_o | output | 1 | Clear one flag |
| flag_set_o | output | 1 | Set one flag |
| flag_idx_o | output | 3 | Flag index |
| rti_o | output | 1 | Return from interrupt |
| usr_src_o | output | 1 | Move source from user bank |
| illegal_o | output | 1 | Illegal instruction |
| prefix_o | output | 1 | Word was a prefix or alternate-set word |

## Verification
The directed patterns cover each opcode group with register fields that differ from one another, so a swapped field shows up. Each multiply and memory word is placed after every alternate code, which shows whether the code is applied and whether it is dropped afterwards. Prefix chains are followed by consumers of each constant width, with idle cycles, alternate words or illegal words in between. These sequences separate accumulation from replacement, show the shift applied for each width, and show when the state is cleared. Random streams that mix in prefixes are then compared against the model on every cycle.

// File: rtl/dec_pkg.sv
package dec_pkg;

   localparam int INSN_W = 16;
   localparam int PFX_W  = 12;
   localparam int KMAX_W = 9;

   typedef enum logic [4:0] {
      OP_NOP  = 5'd0,  OP_ADD  = 5'd1,  OP_ADC  = 5'd2,  OP_RSB   = 5'd3,
      OP_RSBC = 5'd4,  OP_AND  = 5'd5,  OP_OR   = 5'd6,  OP_XOR   = 5'd7,
      OP_MUL  = 5'd8,  OP_SMUL = 5'd9,  OP_DIV  = 5'd10, OP_SDIV  = 5'd11,
      OP_MOV  = 5'd12, OP_ROR  = 5'd13, OP_ROL  = 5'd14, OP_LSL   = 5'd15,
      OP_LSR  = 5'd16, OP_ROR16 = 5'd17, OP_ROL16 = 5'd18, OP_SXT = 5'd19
   } alu_op_e;

   typedef enum logic [1:0] {
      AM_OFS = 2'd0, AM_POSTDEC = 2'd1, AM_PREINC = 2'd2
   } addr_mode_e;

   typedef enum logic [2:0] {
      KW_NONE = 3'd0, KW_4 = 3'd1, KW_5 = 3'd2, KW_6 = 3'd3, KW_9 = 3'd4
   } kw_e;

   typedef struct packed {
      alu_op_e           op;
      logic [2:0]        rd;
      logic [2:0]        rs1;
      logic [2:0]        rs2;
      logic              use_imm;
      kw_e               kw;
      logic [KMAX_W-1:0] k;
      logic [1:0]        size;
      logic              load;
      logic              store;
      logic              branch;
      logic              link;
      addr_mode_e        am;
      logic              f_rd;
      logic              f_wr;
      logic              f_clr;
      logic              f_set;
      logic              rti;
      logic              usr_src;
      logic              illegal;
      logic              pfx;
      logic              alt;
      logic [1:0]        alt_ext;
   } dec_t;

endpackage

// File: rtl/dec_pfx_state.sv
module dec_pfx_state
   import dec_pkg::*;
#(
   parameter int IMM_W     = 32,
   parameter bit PFX_CHAIN = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             valid_i,
   input  logic             pfx_i,
   input  logic [PFX_W-1:0] pk_i,
   input  logic             alt_i,
   input  logic [1:0]       alt_ext_i,
   output logic [IMM_W-1:0] pend_o,
   output logic [1:0]       ext_o
);

   logic [IMM_W-1:0] pend_q, pend_nxt;
   logic [1:0]       ext_q;

   generate
      if (PFX_CHAIN) begin : g_chain
         assign pend_nxt = (pend_q << PFX_W) | IMM_W'(pk_i);
      end else begin : g_replace
         assign pend_nxt = IMM_W'(pk_i);
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         pend_q <= '0;
         ext_q  <= 2'd0;
      end else if (valid_i) begin
         if (pfx_i) begin
            pend_q <= pend_nxt;
         end else if (alt_i) begin
            ext_q  <= alt_ext_i;
         end else begin
            pend_q <= '0;
            ext_q  <= 2'd0;
         end
      end
   end

   assign pend_o = pend_q;
   assign ext_o  = ext_q;

   // R9
   clear_after_plain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && !pfx_i && !alt_i) |=> (pend_o == '0 && ext_o == 2'd0));

   // R9
   alt_keeps_pfx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && alt_i && !pfx_i) |=> (ext_o == $past(alt_ext_i) && $stable(pend_o)));

   // R1
   idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> ($stable(pend_o) && $stable(ext_o)));

endmodule

// File: rtl/dec_imm.sv
module dec_imm
   import dec_pkg::*;
#(
   parameter int IMM_W = 32
) (
   input  logic [IMM_W-1:0]  pend_i,
   input  kw_e               kw_i,
   input  logic [KMAX_W-1:0] k_i,
   output logic [IMM_W-1:0]  imm_o
);

   always_comb begin
      case (kw_i)
         KW_4:    imm_o = (pend_i << 4) | IMM_W'(k_i[3:0]);
         KW_5:    imm_o = (pend_i << 5) | IMM_W'(k_i[4:0]);
         KW_6:    imm_o = (pend_i << 6) | IMM_W'(k_i[5:0]);
         KW_9:    imm_o = (pend_i << 9) | IMM_W'(k_i);
         default: imm_o = '0;
      endcase
   end

endmodule

// File: rtl/dec_core.sv
module dec_core
   import dec_pkg::*;
(
   input  logic [INSN_W-1:0] instr_i,
   input  logic [1:0]        ext_i,
   output dec_t              d_o
);

   logic [3:0] grp;
   logic [5:0] sub;
   alu_op_e    md_op;

   assign grp   = instr_i[15:12];
   assign sub   = instr_i[11:6];
   assign md_op = alu_op_e'(5'(OP_MUL) + 5'(ext_i));

   always_comb begin
      d_o     = '0;
      d_o.rd  = instr_i[2:0];
      d_o.rs1 = instr_i[5:3];
      d_o.rs2 = instr_i[8:6];
      d_o.k   = KMAX_W'(instr_i[11:6]);
      case (grp)
         4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6: begin
            d_o.op      = alu_op_e'(5'(grp) + 5'd1);
            d_o.use_imm = 1'b1;
            d_o.kw      = KW_6;
         end
         4'h7: begin
            d_o.op      = md_op;
            d_o.use_imm = 1'b1;
            d_o.kw      = KW_6;
         end
         4'h8, 4'h9: begin
            d_o.kw  = KW_6;
            d_o.rs2 = instr_i[2:0];
            if (ext_i == 2'd3) begin
               d_o.illegal = 1'b1;
            end else begin
               d_o.size  = ext_i;
               d_o.load  = ~grp[0];
               d_o.store = grp[0];
            end
         end
         4'hA, 4'hB: begin
            d_o.kw     = KW_6;
            d_o.branch = 1'b1;
            d_o.link   = grp[0];
         end
         4'hC: begin
            if (instr_i[11:9] == 3'd7) d_o.op = md_op;
            else                       d_o.op = alu_op_e'(5'(instr_i[11:9]) + 5'd1);
         end
         4'hD: begin
            d_o.op      = OP_MOV;
            d_o.use_imm = 1'b1;
            d_o.kw      = KW_9;
            d_o.k       = instr_i[11:3];
         end
         4'hE: d_o.pfx = 1'b1;
         default: begin
            casez (sub)
               6'b00????: begin
                  d_o.op      = alu_op_e'(5'(OP_ROR) + 5'(instr_i[9:8]));
                  d_o.rs1     = instr_i[2:0];
                  d_o.use_imm = 1'b1;
                  d_o.kw      = KW_5;
                  d_o.k       = KMAX_W'(instr_i[7:3]);
               end
               6'b0100??: begin
                  d_o.op      = OP_MOV;
                  d_o.rti     = instr_i[7];
                  d_o.usr_src = instr_i[6];
               end
               6'b0101??: begin
                  d_o.op  = alu_op_e'(5'(OP_ROR) + 5'(instr_i[7:6]));
                  d_o.rs1 = instr_i[2:0];
                  d_o.rs2 = instr_i[5:3];
               end
               6'b011000: begin
                  d_o.store = 1'b1;
                  d_o.am    = AM_POSTDEC;
                  d_o.rs2   = instr_i[2:0];
               end
               6'b011001: begin
                  d_o.load = 1'b1;
                  d_o.am   = AM_PREINC;
               end
               6'b011010, 6'b011011: begin
                  d_o.op  = instr_i[6] ? OP_ROL16 : OP_ROR16;
                  d_o.rs1 = instr_i[2:0];
                  d_o.rs2 = instr_i[5:3];
               end
               6'b011100: d_o.op = OP_SXT;
               6'b011101: begin
                  case (instr_i[5:3])
                     3'd0: d_o.f_rd = 1'b1;
                     3'd1: begin
                        d_o.f_wr = 1'b1;
                        d_o.rs1  = instr_i[2:0];
                     end
                     3'd2: d_o.f_clr = 1'b1;
                     3'd3: d_o.f_set = 1'b1;
                     3'd4: begin
                        d_o.alt     = 1'b1;
                        d_o.alt_ext = instr_i[1:0];
                     end
                     default: d_o.illegal = 1'b1;
                  endcase
               end
               6'b1000??: begin
                  d_o.op      = instr_i[7] ? OP_ROL16 : OP_ROR16;
                  d_o.rs1     = instr_i[2:0];
                  d_o.use_imm = 1'b1;
                  d_o.kw      = KW_4;
                  d_o.k       = KMAX_W'(instr_i[6:3]);
               end
               default: d_o.illegal = 1'b1;
            endcase
         end
      endcase
   end

endmodule

// File: rtl/insn_prefix_decoder.sv
module insn_prefix_decoder
   import dec_pkg::*;
#(
   parameter int IMM_W     = 32,
   parameter bit PFX_CHAIN = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             valid_i,
   input  logic [15:0]      instr_i,
   output logic [4:0]       alu_op_o,
   output logic [2:0]       rd_o,
   output logic [2:0]       rs1_o,
   output logic [2:0]       rs2_o,
   output logic [IMM_W-1:0] imm_o,
   output logic             use_imm_o,
   output logic [1:0]       mem_size_o,
   output logic             load_o,
   output logic             store_o,
   output logic             branch_o,
   output logic             link_o,
   output logic [2:0]       cond_o,
   output logic [1:0]       addr_mode_o,
   output logic             flag_rd_o,
   output logic             flag_wr_o,
   output logic             flag_clr_o,
   output logic             flag_set_o,
   output logic [2:0]       flag_idx_o,
   output logic             rti_o,
   output logic             usr_src_o,
   output logic             illegal_o,
   output logic             prefix_o
);

   generate
      if (IMM_W < PFX_W + KMAX_W) begin : g_bad_imm_w
         $error("IMM_W must hold a prefix plus the widest constant field");
      end
   endgenerate

   dec_t             d;
   logic [IMM_W-1:0] pend;
   logic [1:0]       ext;

   dec_core u_core (
      .instr_i (instr_i),
      .ext_i   (ext),
      .d_o     (d)
   );

   dec_pfx_state #(.IMM_W(IMM_W), .PFX_CHAIN(PFX_CHAIN)) u_state (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .valid_i   (valid_i),
      .pfx_i     (d.pfx),
      .pk_i      (instr_i[PFX_W-1:0]),
      .alt_i     (d.alt),
      .alt_ext_i (d.alt_ext),
      .pend_o    (pend),
      .ext_o     (ext)
   );

   dec_imm #(.IMM_W(IMM_W)) u_imm (
      .pend_i (pend),
      .kw_i   (d.kw),
      .k_i    (d.k),
      .imm_o  (imm_o)
   );

   assign alu_op_o    = valid_i ? d.op : OP_NOP;
   assign rd_o        = d.rd;
   assign rs1_o       = d.rs1;
   assign rs2_o       = d.rs2;
   assign cond_o      = instr_i[2:0];
   assign flag_idx_o  = instr_i[2:0];
   assign mem_size_o  = d.size;
   assign use_imm_o   = valid_i & d.use_imm;
   assign load_o      = valid_i & d.load;
   assign store_o     = valid_i & d.store;
   assign branch_o    = valid_i & d.branch;
   assign link_o      = valid_i & d.link;
   assign addr_mode_o = valid_i ? d.am : AM_OFS;
   assign flag_rd_o   = valid_i & d.f_rd;
   assign flag_wr_o   = valid_i & d.f_wr;
   assign flag_clr_o  = valid_i & d.f_clr;
   assign flag_set_o  = valid_i & d.f_set;
   assign rti_o       = valid_i & d.rti;
   assign usr_src_o   = valid_i & d.usr_src;
   assign illegal_o   = valid_i & d.illegal;
   assign prefix_o    = valid_i & (d.pfx | d.alt);

   // R14
   illegal_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      illegal_o |-> (alu_op_o == 5'd0 && !load_o && !store_o && !branch_o &&
                     !flag_rd_o && !flag_wr_o && !flag_clr_o && !flag_set_o &&
                     !rti_o && !prefix_o));

   // R1
   idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |-> ($countones({load_o, store_o, branch_o, illegal_o, prefix_o,
                                flag_rd_o, flag_wr_o, flag_clr_o, flag_set_o}) == 0));

   // R10
   mem_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({load_o, store_o, branch_o}));

   // R10
   postdec_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (addr_mode_o == 2'd1) |-> store_o);

   // R5
   size_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load_o || store_o) |-> (mem_size_o != 2'd3));

endmodule

// File: tb/tb_insn_prefix_decoder.sv
module tb_insn_prefix_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid = 1'b0;
   logic [15:0] instr = 16'h0;

   logic [4:0]  alu_op_o;
   logic [2:0]  rd_o, rs1_o, rs2_o, cond_o, flag_idx_o;
   logic [31:0] imm_o;
   logic        use_imm_o, load_o, store_o, branch_o, link_o;
   logic [1:0]  mem_size_o, addr_mode_o;
   logic        flag_rd_o, flag_wr_o, flag_clr_o, flag_set_o;
   logic        rti_o, usr_src_o, illegal_o, prefix_o;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   insn_prefix_decoder dut (
      .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .instr_i(instr),
      .alu_op_o(alu_op_o), .rd_o(rd_o), .rs1_o(rs1_o), .rs2_o(rs2_o),
      .imm_o(imm_o), .use_imm_o(use_imm_o), .mem_size_o(mem_size_o),
      .load_o(load_o), .store_o(store_o), .branch_o(branch_o), .link_o(link_o),
      .cond_o(cond_o), .addr_mode_o(addr_mode_o), .flag_rd_o(flag_rd_o),
      .flag_wr_o(flag_wr_o), .flag_clr_o(flag_clr_o), .flag_set_o(flag_set_o),
      .flag_idx_o(flag_idx_o), .rti_o(rti_o), .usr_src_o(usr_src_o),
      .illegal_o(illegal_o), .prefix_o(prefix_o)
   );

   // reference model state
   logic [31:0] m_pend = 32'd0;
   int          m_ext  = 0;

   // expected values and compare masks
   string       tag;
   int          e_op, e_rd, e_rs1, e_rs2, e_size, e_cond, e_fidx;
   logic [31:0] e_imm;
   logic [14:0] e_strb;
   bit          c_rd, c_rs1, c_rs2, c_imm, c_size, c_cond, c_fidx;

   task automatic chk(input string t, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h (instr %h)", t, what, act, exp, instr);
      end
   endtask

   task automatic model(input logic v, input logic [15:0] w);
      logic [3:0] g;
      logic [5:0] s;
      logic [2:0] rx, ry;
      bit ld, st, br, lk, frd, fwr, fcl, fst, rti, usr, ill, pfx, ui;
      int am;
      g = w[15:12]; s = w[11:6]; rx = w[2:0]; ry = w[5:3];
      ld = 0; st = 0; br = 0; lk = 0; frd = 0; fwr = 0; fcl = 0; fst = 0;
      rti = 0; usr = 0; ill = 0; pfx = 0; ui = 0; am = 0;
      e_op = 0; e_rd = rx; e_rs1 = ry; e_rs2 = 0; e_size = 0; e_cond = rx; e_fidx = rx;
      e_imm = 0;
      c_rd = 0; c_rs1 = 0; c_rs2 = 0; c_imm = 0; c_size = 0; c_cond = 0; c_fidx = 0;
      tag = "R1";
      if (v) begin
         if (g <= 6) begin
            tag = "R2"; e_op = int'(g) + 1; ui = 1;
            e_imm = (m_pend << 6) | 32'(w[11:6]); c_rd = 1; c_rs1 = 1; c_imm = 1;
         end else if (g == 7) begin
            tag = "R4"; e_op = 8 + m_ext; ui = 1;
            e_imm = (m_pend << 6) | 32'(w[11:6]); c_rd = 1; c_rs1 = 1; c_imm = 1;
         end else if (g == 8 || g == 9) begin
            tag = "R5";
            if (m_ext == 3) ill = 1;
            else begin
               ld = (g == 8); st = (g == 9); e_size = m_ext; c_size = 1;
               e_imm = (m_pend << 6) | 32'(w[11:6]); c_imm = 1; c_rs1 = 1;
               if (ld) c_rd = 1; else begin e_rs2 = rx; c_rs2 = 1; end
            end
         end else if (g == 10 || g == 11) begin
            tag = "R6"; br = 1; lk = (g == 11); c_cond = 1; c_rs1 = 1;
            e_imm = (m_pend << 6) | 32'(w[11:6]); c_imm = 1;
         end else if (g == 12) begin
            tag = "R3"; e_rs2 = w[8:6]; c_rd = 1; c_rs1 = 1; c_rs2 = 1;
            if (w[11:9] == 3'd7) begin tag = "R4"; e_op = 8 + m_ext; end
            else e_op = int'(w[11:9]) + 1;
         end else if (g == 13) begin
            tag = "R7"; e_op = 12; ui = 1; c_rd = 1;
            e_imm = (m_pend << 9) | 32'(w[11:3]); c_imm = 1;
         end else if (g == 14) begin
            tag = "R8"; pfx = 1;
         end else if (s[5:4] == 2'b00) begin
            tag = "R13"; e_op = 13 + int'(w[9:8]); ui = 1; e_rs1 = rx;
            c_rd = 1; c_rs1 = 1; e_imm = (m_pend << 5) | 32'(w[7:3]); c_imm = 1;
         end else if (s[5:2] == 4'b0100) begin
            tag = "R12"; e_op = 12; rti = w[7]; usr = w[6]; c_rd = 1; c_rs1 = 1;
         end else if (s[5:2] == 4'b0101) begin
            tag = "R13"; e_op = 13 + int'(w[7:6]); e_rs1 = rx; e_rs2 = ry;
            c_rd = 1; c_rs1 = 1; c_rs2 = 1;
         end else if (s == 6'd24) begin
            tag = "R10"; st = 1; am = 1; e_rs2 = rx; c_rs1 = 1; c_rs2 = 1; c_size = 1;
         end else if (s == 6'd25) begin
            tag = "R10"; ld = 1; am = 2; c_rd = 1; c_rs1 = 1; c_size = 1;
         end else if (s == 6'd26 || s == 6'd27) begin
            tag = "R13"; e_op = (s == 6'd26) ? 17 : 18; e_rs1 = rx; e_rs2 = ry;
            c_rd = 1; c_rs1 = 1; c_rs2 = 1;
         end else if (s == 6'd28) begin
            tag = "R13"; e_op = 19; c_rd = 1; c_rs1 = 1;
         end else if (s == 6'd29) begin
            tag = "R11";
            case (w[5:3])
               3'd0: begin frd = 1; c_rd = 1; end
               3'd1: begin fwr = 1; e_rs1 = rx; c_rs1 = 1; end
               3'd2: begin fcl = 1; c_fidx = 1; end
               3'd3: begin fst = 1; c_fidx = 1; end
               3'd4: begin tag = "R9"; pfx = 1; end
               default: begin tag = "R14"; ill = 1; end
            endcase
         end else if (s[5:2] == 4'b1000) begin
            tag = "R13"; e_op = w[7] ? 18 : 17; ui = 1; e_rs1 = rx;
            c_rd = 1; c_rs1 = 1; e_imm = (m_pend << 4) | 32'(w[6:3]); c_imm = 1;
         end else begin
            tag = "R14"; ill = 1;
         end
         if (ill) tag = "R14";
      end
      e_strb = {ld, st, br, lk, frd, fwr, fcl, fst, rti, usr, ill, pfx, ui, 2'(am)};
   endtask

   task automatic update(input logic v, input logic [15:0] w);
      if (v) begin
         if (w[15:12] == 4'hE) m_pend = (m_pend << 12) | 32'(w[11:0]);
         else if (w[15:3] == 13'h1EEC) m_ext = int'(w[1:0]);
         else begin m_pend = 32'd0; m_ext = 0; end
      end
   endtask

   task automatic step(input logic v, input logic [15:0] w);
      @(negedge clk);
      valid = v;
      instr = w;
      #4;
      model(v, w);
      chk(tag, "op", alu_op_o, e_op);
      chk(tag, "strobes", {load_o, store_o, branch_o, link_o, flag_rd_o, flag_wr_o,
                           flag_clr_o, flag_set_o, rti_o, usr_src_o, illegal_o,
                           prefix_o, use_imm_o, addr_mode_o}, e_strb);
      if (c_rd)   chk(tag, "rd", rd_o, e_rd);
      if (c_rs1)  chk(tag, "rs1", rs1_o, e_rs1);
      if (c_rs2)  chk(tag, "rs2", rs2_o, e_rs2);
      if (c_imm)  chk(tag, "imm", imm_o, e_imm);
      if (c_size) chk(tag, "size", mem_size_o, e_size);
      if (c_cond) chk(tag, "cond", cond_o, e_cond);
      if (c_fidx) chk(tag, "flag_idx", flag_idx_o, e_fidx);
      update(v, w);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      #1_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: idle outputs, then fresh state after reset
      step(0, 16'hFFFF);
      step(1, 16'hD000 | (16'h1A5 << 3) | 16'h3);
      // R2: constant-form ALU ops
      for (int g = 0; g < 7; g++) step(1, 16'((g << 12) | (37 << 6) | (5 << 3) | 2));
      // R3: three-register ops
      for (int o = 0; o < 7; o++) step(1, 16'(16'hC000 | (o << 9) | (6 << 6) | (1 << 3) | 4));
      // R4: multiply class under each alternate code, then code dropped
      for (int e = 0; e < 4; e++) begin
         step(1, 16'(16'hF760 | e));
         step(1, 16'h7000 | (16'd9 << 6) | (16'd2 << 3) | 16'd1);
         step(1, 16'hCE00 | (16'd3 << 6) | (16'd4 << 3) | 16'd5);
      end
      // R5: load/store sizes including illegal code
      for (int e = 0; e < 4; e++) begin
         step(1, 16'(16'hF760 | e));
         step(1, 16'h8000 | (16'd60 << 6) | (16'd7 << 3) | 16'd6);
         step(1, 16'(16'hF760 | e));
         step(1, 16'h9000 | (16'd3 << 6) | (16'd1 << 3) | 16'd5);
      end
      // R6: branch and branch-and-link
      step(1, 16'hA000 | (16'd17 << 6) | (16'd7 << 3) | 16'd4);
      step(1, 16'hB000 | (16'd42 << 6) | (16'd2 << 3) | 16'd6);
      // R7
      step(1, 16'hDFFF);
      // R8: prefix widens, chains, survives idle cycles
      step(1, 16'hEABC);
      step(0, 16'h0000);
      step(1, 16'hD000 | (16'h155 << 3) | 16'd1);
      step(1, 16'hE123);
      step(1, 16'hE456);
      step(1, 16'h0000 | (16'd63 << 6) | (16'd1 << 3) | 16'd2);
      step(1, 16'hE00F);
      step(1, 16'hF000 | (16'd31 << 3) | 16'd3);
      step(1, 16'hE00F);
      step(1, 16'hF800 | (16'd9 << 3) | 16'd3);
      // R9: prefix and alternate coexist, then cleared
      step(1, 16'hE777);
      step(1, 16'hF762);
      step(1, 16'h8000 | (16'd5 << 6) | (16'd3 << 3) | 16'd0);
      step(1, 16'h8000 | (16'd5 << 6) | (16'd3 << 3) | 16'd0);
      step(1, 16'hE001);
      step(1, 16'hC0D1);
      step(1, 16'hD008);
      // R10: push and pop
      step(1, 16'hF600 | (16'd6 << 3) | 16'd2);
      step(1, 16'hF640 | (16'd6 << 3) | 16'd3);
      // R11: flag access
      step(1, 16'hF745);
      step(1, 16'hF74E);
      step(1, 16'hF753);
      step(1, 16'hF75C);
      // R12: moves
      step(1, 16'hF400 | (16'd1 << 3) | 16'd7);
      step(1, 16'hF4C0 | (16'd7 << 3) | 16'd7);
      step(1, 16'hF440 | (16'd2 << 3) | 16'd3);
      // R13: shifts and sign-extend
      for (int o = 0; o < 4; o++) step(1, 16'(16'hF000 | (o << 8) | (11 << 3) | 5));
      for (int o = 0; o < 4; o++) step(1, 16'(16'hF500 | (o << 6) | (2 << 3) | 6));
      step(1, 16'hF680 | (16'd3 << 3) | 16'd1);
      step(1, 16'hF6C0 | (16'd4 << 3) | 16'd2);
      step(1, 16'hF700 | (16'd5 << 3) | 16'd6);
      step(1, 16'hF880 | (16'd15 << 3) | 16'd0);
      // R14: spare words, and illegal clears pending state
      step(1, 16'hF768);
      step(1, 16'hF77F);
      step(1, 16'hF780);
      step(1, 16'hF7C0);
      step(1, 16'hF900);
      step(1, 16'hFFFF);
      step(1, 16'hE0F0);
      step(1, 16'hF763);
      step(1, 16'hFA00);
      step(1, 16'h7000);
      step(1, 16'hD010);
      // random streams with prefixes mixed in
      for (int i = 0; i < 4000; i++) begin
         logic [15:0] w;
         int r;
         w = 16'($urandom);
         r = int'($urandom_range(0, 9));
         if (r == 0) w[15:12] = 4'hE;
         else if (r == 1) w = 16'(16'hF760 | (w & 16'h3));
         step(($urandom_range(0, 4) != 0), w);
      end
      finish_run();
   end

endmodule